// File: doc/BRIEF.md
# Fail-Safe Clock Monitor Controller

This block watches an external oscillator and moves the system onto an internal oscillator when the external one stops. The controller runs on a free-running control clock taken from the internal oscillator. A second, slower sampling clock sets the observation window. Both the external clock and the sampling clock are brought into the control clock domain through multi-flop synchronisers. A detection latch inside the block is set by each synchronised falling edge of the external clock and is cleared by each rising edge of the sampling clock. When the sampling clock falls half a period later, the latch is examined. If it is still clear, the external oscillator is declared dead.

On a fault the block drops its external-select output, enters the fail-safe condition and sets a sticky fault flag. An interrupt request is raised while both the flag and its enable are set. The fail-safe condition ends in one of three ways: a reset, a sleep request, or a change of the software clock-select bit. Leaving fail-safe through sleep wake-up or a select change first runs a start-up timer, which counts a parameterised number of external clock edges. The external clock is selected again only when that timer expires. In external-clock mode there is no start-up timer, so these transitions complete at once.

The glitch-free clock multiplexer is outside this block and is driven from the select outputs. A 3-bit internal frequency choice is passed through, registered, to that multiplexer.

Top module: `clkmon_failsafe`

## Requirements
- R1: After reset with `ec_mode`=0, `sel_ext`, `ext_ready`, `fault_flag`, `fault_irq` and `failsafe` are all 0.
- R2: With `ec_mode`=0, after reset or sleep wake-up `sel_ext` stays 0 until `OST_EDGES` synchronised rising edges of `ext_clk` have been counted, and then becomes 1 (when `scs_int`=0). No fault is acted on during this count.
- R3: While `ext_clk` shows at least one falling edge in every half period of `samp_clk`, no fault is raised and `sel_ext` stays 1.
- R4: While the external clock is selected, a fault is declared if no synchronised falling edge of `ext_clk` is seen between a rising edge of `samp_clk` and the next falling edge. The first falling edge after reset is not evaluated. A fault sets `failsafe`=1 and `sel_ext`=0 within about 1.5 sampling periods of the clock stopping, plus a few control cycles.
- R5: A fault sets `fault_flag` to 1. The flag then holds until software clears it.
- R6: `fault_irq` is 1 exactly when `fault_flag`=1 and `fault_ie`=1.
- R7: A `flag_clr` pulse is ignored while `failsafe`=1. When `failsafe`=0, the pulse clears `fault_flag` on the next control clock edge.
- R8: Any change of `scs_int` restarts the start-up timer from zero. While the timer runs, `sel_ext`=0 and `failsafe` keeps its value.
- R9: When the start-up timer expires, `failsafe` clears. `sel_ext` becomes 1 if `scs_int`=0. If `scs_int`=1, the internal source stays selected.
- R10: `int_freq_out` equals the `int_freq_sel` value of the previous control clock cycle, in every state, including fail-safe.
- R11: `sleep_req`=1 clears `failsafe` and forces `sel_ext`=0 on the next edge. When `sleep_req` falls, the start-up timer runs again (R2).
- R12: With `ec_mode`=1 no start-up timer is used. `sel_ext`=1 within a few control cycles after reset, and a change of `scs_int` out of fail-safe takes effect at once.
- R13: `ext_ready` is 1 exactly when the external clock is selected and running (the same cycles as `sel_ext`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock from the internal oscillator |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_clk | input | 1 | Monitored external oscillator |
| samp_clk | input | 1 | Slow sampling clock that sets the detection window |
| ec_mode | input | 1 | 1: external clock needs no start-up timer |
| scs_int | input | 1 | Software clock select, 1 requests the internal source |
| sleep_req | input | 1 | Sleep request, level |
| fault_ie | input | 1 | Fault interrupt enable |
| flag_clr | input | 1 | One-cycle pulse that clears the fault flag |
| int_freq_sel | input | FSEL_W | Internal oscillator frequency choice |
| sel_ext | output | 1 | 1 selects the external clock at the multiplexer |
| int_freq_out | output | FSEL_W | Registered frequency choice to the internal oscillator |
| fault_flag | output | 1 | Sticky oscillator fault flag |
| fault_irq | output | 1 | Interrupt request |
| failsafe | output | 1 | Fail-safe condition active |
| ext_ready | output | 1 | External oscillator started and selected |

## Verification
A detection latch stuck high would hide a dead oscillator: `failsafe` would never rise after the clock stops, and this shows within two sampling periods. A latch stuck low, or a missing arm bit, would raise `failsafe` while the clock is healthy, which also shows within one or two sampling periods. A start-up counter with the wrong limit or a missed restart moves the rising edge of `sel_ext` by whole external clock periods, so the bench samples well before and well after the nominal timeout. A fault flag clear that is not gated by the fail-safe state shows on `fault_flag` one cycle after the pulse.

// File: rtl/clkmon_pkg.sv
`timescale 1ns/1ps
package clkmon_pkg;
  typedef enum logic [2:0] {
    CM_WAKE  = 3'd0,
    CM_BOOT  = 3'd1,
    CM_EXT   = 3'd2,
    CM_FAIL  = 3'd3,
    CM_INT   = 3'd4
  } cm_state_e;
endpackage

// File: rtl/clkmon_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser with edge pulses in the destination domain.
module clkmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // sh_q[STAGES-1] is the synchronised level, sh_q[STAGES] its previous value
  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/clkmon_detect.sv
`timescale 1ns/1ps
// Dead-clock detector: latch set by external falling edges, cleared by
// sampling rising edges, evaluated on sampling falling edges.
module clkmon_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_fall,
  input  logic samp_rise,
  input  logic samp_fall,
  output logic miss
);
  logic seen_q, seen_d;
  logic armed_q, armed_d;

  always_comb begin
    seen_d  = seen_q;
    armed_d = armed_q;
    if (samp_rise) begin
      seen_d  = ext_fall;
      armed_d = 1'b1;
    end else if (ext_fall) begin
      seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      seen_q  <= seen_d;
      armed_q <= armed_d;
    end
  end

  // an edge landing in the evaluation cycle still counts as activity
  assign miss = samp_fall & armed_q & ~seen_q & ~ext_fall;
endmodule

// File: rtl/clkmon_ost.sv
`timescale 1ns/1ps
// Start-up timer counting external clock edges.
module clkmon_ost #(
  parameter int EDGES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int W = $clog2(EDGES + 1);
  localparam logic [W-1:0] LAST = W'(EDGES - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         hit;

  assign hit  = run & tick & (cnt_q == LAST);
  assign done = hit & ~restart;

  always_comb begin
    cnt_d = cnt_q;
    if (restart || hit)     cnt_d = '0;
    else if (run && tick)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/clkmon_ctrl.sv
`timescale 1ns/1ps
// Control state machine and fault flag.
module clkmon_ctrl
  import clkmon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ec_mode,
  input  logic scs_int,
  input  logic sleep_req,
  input  logic flag_clr,
  input  logic miss,
  input  logic ost_done,
  output logic ost_restart,
  output logic ost_run,
  output logic sel_ext,
  output logic fault_flag,
  output logic failsafe
);
  cm_state_e state_q, state_d;
  logic      fs_q, fs_d;
  logic      flag_q, flag_d;
  logic      scs_q;
  logic      scs_chg;
  logic      fault_evt;

  assign scs_chg = scs_int ^ scs_q;

  always_comb begin
    state_d     = state_q;
    fs_d        = fs_q;
    ost_restart = 1'b0;
    fault_evt   = 1'b0;
    if (sleep_req) begin
      state_d = CM_WAKE;
      fs_d    = 1'b0;
    end else begin
      unique case (state_q)
        CM_WAKE: begin
          if (ec_mode) begin
            state_d = scs_int ? CM_INT : CM_EXT;
          end else begin
            state_d     = CM_BOOT;
            ost_restart = 1'b1;
          end
        end
        CM_BOOT: begin
          if (scs_chg) begin
            ost_restart = 1'b1;
          end else if (ost_done) begin
            state_d = scs_int ? CM_INT : CM_EXT;
            fs_d    = 1'b0;
          end
        end
        CM_EXT: begin
          if (miss) begin
            state_d   = CM_FAIL;
            fs_d      = 1'b1;
            fault_evt = 1'b1;
          end else if (scs_chg) begin
            if (ec_mode) begin
              state_d = scs_int ? CM_INT : CM_EXT;
            end else begin
              state_d     = CM_BOOT;
              ost_restart = 1'b1;
            end
          end
        end
        CM_FAIL, CM_INT: begin
          if (scs_chg) begin
            if (ec_mode) begin
              state_d = scs_int ? CM_INT : CM_EXT;
              fs_d    = 1'b0;
            end else begin
              state_d     = CM_BOOT;
              ost_restart = 1'b1;
            end
          end
        end
        default: state_d = CM_WAKE;
      endcase
    end
  end

  always_comb begin
    flag_d = flag_q;
    if (fault_evt)              flag_d = 1'b1;
    else if (flag_clr && !fs_q) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CM_WAKE;
      fs_q    <= 1'b0;
      flag_q  <= 1'b0;
      scs_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      fs_q    <= fs_d;
      flag_q  <= flag_d;
      scs_q   <= scs_int;
    end
  end

  assign ost_run    = (state_q == CM_BOOT);
  assign sel_ext    = (state_q == CM_EXT);
  assign fault_flag = flag_q;
  assign failsafe   = fs_q;
endmodule

// File: rtl/clkmon_failsafe.sv
`timescale 1ns/1ps
module clkmon_failsafe #(
  parameter int OST_EDGES   = 1024,
  parameter int SYNC_STAGES = 2,
  parameter int FSEL_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk,
  input  logic              samp_clk,
  input  logic              ec_mode,
  input  logic              scs_int,
  input  logic              sleep_req,
  input  logic              fault_ie,
  input  logic              flag_clr,
  input  logic [FSEL_W-1:0] int_freq_sel,
  output logic              sel_ext,
  output logic [FSEL_W-1:0] int_freq_out,
  output logic              fault_flag,
  output logic              fault_irq,
  output logic              failsafe,
  output logic              ext_ready
);
  logic [1:0] rst_sh_q;
  logic       rst_sync_n;
  logic       ext_rise, ext_fall;
  logic       samp_rise, samp_fall;
  logic       miss;
  logic       ost_restart, ost_run, ost_done;
  logic       sel_ext_w;
  logic [FSEL_W-1:0] freq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sh_q[1];

  clkmon_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(ext_clk), .rise(ext_rise), .fall(ext_fall)
  );

  clkmon_sync #(.STAGES(SYNC_STAGES)) u_samp_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(samp_clk), .rise(samp_rise), .fall(samp_fall)
  );

  clkmon_detect u_detect (
    .clk(clk), .rst_n(rst_sync_n), .ext_fall(ext_fall),
    .samp_rise(samp_rise), .samp_fall(samp_fall), .miss(miss)
  );

  clkmon_ost #(.EDGES(OST_EDGES)) u_ost (
    .clk(clk), .rst_n(rst_sync_n), .restart(ost_restart),
    .run(ost_run), .tick(ext_rise), .done(ost_done)
  );

  clkmon_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .ec_mode(ec_mode), .scs_int(scs_int),
    .sleep_req(sleep_req), .flag_clr(flag_clr), .miss(miss),
    .ost_done(ost_done), .ost_restart(ost_restart), .ost_run(ost_run),
    .sel_ext(sel_ext_w), .fault_flag(fault_flag), .failsafe(failsafe)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) freq_q <= '0;
    else             freq_q <= int_freq_sel;
  end

  assign int_freq_out = freq_q;
  assign sel_ext      = sel_ext_w;
  assign ext_ready    = sel_ext_w;
  assign fault_irq    = fault_flag & fault_ie;
endmodule

// File: rtl/clkmon_failsafe_chk.sv
`timescale 1ns/1ps
module clkmon_failsafe_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep_req,
  input logic flag_clr,
  input logic sel_ext,
  input logic fault_flag,
  input logic failsafe
);
  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (failsafe && fault_flag) |=> fault_flag);

  // R5
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_flag) |-> failsafe);

  // R4
  fs_internal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    failsafe |-> !sel_ext);

  // R11
  sleep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> (!failsafe && !sel_ext));

  // R7
  clr_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !failsafe && !sel_ext && !sleep_req) |=> !fault_flag);
endmodule

bind clkmon_failsafe clkmon_failsafe_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .sleep_req(sleep_req), .flag_clr(flag_clr),
  .sel_ext(sel_ext), .fault_flag(fault_flag), .failsafe(failsafe)
);

// File: tb/clkmon_failsafe_tb.sv
`timescale 1ns/1ps
module clkmon_failsafe_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_clk = 1'b0;
  logic       samp_clk = 1'b0;
  logic       ext_run = 1'b1;
  logic       ec_mode = 1'b0;
  logic       scs_int = 1'b0;
  logic       sleep_req = 1'b0;
  logic       fault_ie = 1'b0;
  logic       flag_clr = 1'b0;
  logic [2:0] int_freq_sel = 3'd0;
  logic       sel_ext, fault_flag, fault_irq, failsafe, ext_ready;
  logic [2:0] int_freq_out;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;
  always #160 samp_clk = ~samp_clk;
  initial forever begin
    #20;
    if (ext_run) ext_clk = ~ext_clk;
  end

  clkmon_failsafe #(.OST_EDGES(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .samp_clk(samp_clk),
    .ec_mode(ec_mode), .scs_int(scs_int), .sleep_req(sleep_req),
    .fault_ie(fault_ie), .flag_clr(flag_clr), .int_freq_sel(int_freq_sel),
    .sel_ext(sel_ext), .int_freq_out(int_freq_out), .fault_flag(fault_flag),
    .fault_irq(fault_irq), .failsafe(failsafe), .ext_ready(ext_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic ec);
    @(negedge clk);
    rst_n = 1'b0; ec_mode = ec; scs_int = 1'b0; sleep_req = 1'b0;
    fault_ie = 1'b0; flag_clr = 1'b0; ext_run = 1'b1;
    #50;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse_clr();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    repeat (3) @(negedge clk);
    chk("R1 sel_ext", sel_ext, 0);
    chk("R1 ext_ready", ext_ready, 0);
    chk("R1 fault_flag", fault_flag, 0);
    chk("R1 fault_irq", fault_irq, 0);
    chk("R1 failsafe", failsafe, 0);
  endtask

  task automatic t_startup();
    #300;
    chk("R2 before timeout", sel_ext, 0);
    chk("R13 not ready", ext_ready, 0);
    #1000;
    chk("R2 after timeout", sel_ext, 1);
    chk("R13 ready", ext_ready, 1);
  endtask

  task automatic t_running();
    #2000;
    chk("R3 no failsafe", failsafe, 0);
    chk("R3 no flag", fault_flag, 0);
    chk("R3 still external", sel_ext, 1);
  endtask

  task automatic t_fault();
    ext_run = 1'b0;
    #800;
    @(negedge clk);
    chk("R4 sel_ext", sel_ext, 0);
    chk("R4 failsafe", failsafe, 1);
    chk("R13 ready drops", ext_ready, 0);
    chk("R5 flag", fault_flag, 1);
    chk("R6 irq disabled", fault_irq, 0);
    fault_ie = 1'b1;
    #1;
    chk("R6 irq enabled", fault_irq, 1);
  endtask

  task automatic t_clr_blocked();
    pulse_clr();
    chk("R7 clear ignored", fault_flag, 1);
  endtask

  task automatic t_scs_restart();
    ext_run = 1'b1;
    #400;
    @(negedge clk); scs_int = 1'b1;
    #100;
    @(negedge clk); scs_int = 1'b0;
    #300;
    chk("R8 internal during timer", sel_ext, 0);
    chk("R8 failsafe held", failsafe, 1);
    #1000;
    chk("R9 external again", sel_ext, 1);
    chk("R9 failsafe cleared", failsafe, 0);
    chk("R5 flag sticky", fault_flag, 1);
    pulse_clr();
    chk("R7 clear accepted", fault_flag, 0);
    chk("R6 irq off", fault_irq, 0);
  endtask

  task automatic t_scs_int();
    @(negedge clk); scs_int = 1'b1;
    #1200;
    chk("R9 internal kept", sel_ext, 0);
    chk("R9 no failsafe", failsafe, 0);
    chk("R13 not ready", ext_ready, 0);
    @(negedge clk); scs_int = 1'b0;
    #1200;
    chk("R9 back external", sel_ext, 1);
  endtask

  task automatic t_freq();
    @(negedge clk); int_freq_sel = 3'd5;
    @(negedge clk);
    chk("R10 freq 5", int_freq_out, 5);
    int_freq_sel = 3'd2;
    @(negedge clk);
    chk("R10 freq 2", int_freq_out, 2);
  endtask

  task automatic t_sleep();
    ext_run = 1'b0;
    #800;
    chk("R4 second fault", failsafe, 1);
    @(negedge clk); int_freq_sel = 3'd6;
    @(negedge clk);
    chk("R10 freq in failsafe", int_freq_out, 6);
    sleep_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 failsafe cleared", failsafe, 0);
    chk("R11 internal", sel_ext, 0);
    pulse_clr();
    chk("R7 clear after sleep", fault_flag, 0);
    ext_run = 1'b1;
    sleep_req = 1'b0;
    #300;
    chk("R11 timer after wake", sel_ext, 0);
    #1000;
    chk("R11 external after wake", sel_ext, 1);
  endtask

  task automatic t_ec();
    do_reset(1'b1);
    repeat (6) @(negedge clk);
    chk("R12 external at once", sel_ext, 1);
    chk("R12 ready", ext_ready, 1);
    ext_run = 1'b0;
    #800;
    chk("R12 fault in ec mode", failsafe, 1);
    ext_run = 1'b1;
    #400;
    @(negedge clk); scs_int = 1'b1;
    @(negedge clk); scs_int = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 immediate return", sel_ext, 1);
    chk("R12 failsafe cleared", failsafe, 0);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_startup();
    t_running();
    t_fault();
    t_clr_blocked();
    t_scs_restart();
    t_scs_int();
    t_freq();
    t_sleep();
    t_ec();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule